// File: doc/BRIEF.md
# Timer-Paced Burst Transfer Engine

This block streams 16-bit items from a source memory into a peripheral transmit FIFO at a steady rate. An internal pacing timer fires once per period. Each firing asks the engine for one burst, and the engine sends a programmed number of items and then waits for the next firing. Burst size and buffer length are set separately. A long buffer can therefore be sent in small, evenly spaced groups, for example three words per tick to a three-channel converter. The processor is interrupted only once, when the whole buffer has gone out.

Two descriptors, each a source address plus an item count, can be used in alternation. In ping-pong mode the engine switches to the other descriptor as soon as the current one finishes. Streaming then goes on with no gap, and software only has to refill the descriptor that has just been released. If the other descriptor has not been refilled in time, the engine stops and reports an underrun.

The output is a valid/ready stream. `out_valid` goes high for each item of a burst. An item is taken only in a cycle where `out_ready` is also high. While `out_ready` is low, `out_valid`, `mem_addr` and `out_data` hold. The memory port is a plain combinational read, and `mem_rdata` must show the half-word at `mem_addr` in the same cycle.

Top module: `paced_burst_dma`

## Requirements
- R1: When enable (offset 0 bit 0) is set, the timer raises one burst request every P+1 cycles, where P is the value at offset 1. Rising edges of `out_valid` are spaced P+1 cycles apart when no burst is deferred.
- R2: Each request starts exactly one burst of B+1 items, where B is the value at offset 2 (range 1 to 1024 items). Between bursts `out_valid` is low for at least one cycle.
- R3: When fewer items remain than the burst size, the burst is cut short to the number that remain.
- R4: The first item of a buffer is read at the descriptor's source byte address. The address rises by 2 after each accepted item, and `out_data` is the memory word at `mem_addr`.
- R5: An item is accepted only when `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_valid` stays high and `mem_addr` does not change.
- R6: On completion of a buffer, the done flag (offset 7 bit 0) is set. `irq` equals the done flag ANDed with the interrupt enable (offset 0 bit 2). Writing 1 to offset 7 bit 0 clears the flag. `irq` never rises while a buffer still has items to send.
- R7: A request that arrives during a burst is held and serviced right after that burst. A further request while one is already held sets the overrun flag (offset 7 bit 1).
- R8: Descriptor A is set at offsets 3 (source) and 4 (count minus one), and descriptor B at offsets 5 and 6. Writing a count marks that descriptor valid (status bits 5 and 6). In ping-pong mode (offset 0 bit 1), a finished descriptor has its valid bit cleared and the engine continues from the other descriptor.
- R9: In ping-pong mode, if the other descriptor is not valid when a buffer finishes, the engine stops and sets the underrun flag (offset 7 bit 2).
- R10: When enable rises, the engine starts from descriptor A. Outside ping-pong mode it stops after that one buffer, and the busy flag (offset 7 bit 3) returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for `reg_addr` (combinational) |
| mem_addr | output | AW | Source byte address of the current item |
| mem_rdata | input | 16 | Memory word at `mem_addr`, same cycle |
| out_valid | output | 1 | Item offered to the peripheral FIFO |
| out_ready | input | 1 | FIFO not full; the item is taken when both are high |
| out_data | output | 16 | Item offered to the FIFO |
| irq | output | 1 | Level interrupt for buffer completion |

## Verification
The assertions assume that `out_ready` may drop in any cycle, that the period does not change while a tick is being issued, and that software does not rewrite the descriptor in flight. The stimulus keeps to these assumptions. It changes configuration only while enable is off, and it refills only descriptors that are idle. The back-pressure patterns are a repeating one-in-three stall and a full stall held across several timer ticks. The full stall is what makes requests pile up and raise the overrun flag.

// File: rtl/paced_burst_pkg.sv
package paced_burst_pkg;
  localparam logic [2:0] OFS_CTRL   = 3'd0;
  localparam logic [2:0] OFS_PERIOD = 3'd1;
  localparam logic [2:0] OFS_BURST  = 3'd2;
  localparam logic [2:0] OFS_SRC_A  = 3'd3;
  localparam logic [2:0] OFS_CNT_A  = 3'd4;
  localparam logic [2:0] OFS_SRC_B  = 3'd5;
  localparam logic [2:0] OFS_CNT_B  = 3'd6;
  localparam logic [2:0] OFS_STAT   = 3'd7;

  localparam int ST_DONE  = 0;
  localparam int ST_OVR   = 1;
  localparam int ST_UDR   = 2;
  localparam int ST_BUSY  = 3;
  localparam int ST_SEL   = 4;
  localparam int ST_VLD_A = 5;
  localparam int ST_VLD_B = 6;
endpackage

// File: rtl/pace_timer.sv
module pace_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [TW-1:0] period,
  input  logic          done_in,
  input  logic          done_clr,
  output logic          tick,
  output logic          raw_done
);
  logic [TW-1:0] cnt_q;

  assign tick = run && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      raw_done <= 1'b0;
    end else begin
      if (!run || cnt_q == '0) cnt_q <= period;
      else                     cnt_q <= cnt_q - TW'(1);
      if (done_in)       raw_done <= 1'b1;
      else if (done_clr) raw_done <= 1'b0;
    end
  end

  // R1: a nonzero period never yields ticks on consecutive cycles
  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && period != '0) |=> !tick);
  // R6: completion from the engine is latched as raw done status
  p_done_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_in |=> raw_done);
endmodule

// File: rtl/pace_regs.sv
module pace_regs
  import paced_burst_pkg::*;
#(
  parameter int AW = 16,
  parameter int TW = 16,
  parameter int CW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          en,
  output logic          pp,
  output logic          ie,
  output logic [TW-1:0] period,
  output logic [CW-1:0] burst_m1,
  output logic [AW-1:0] src_a,
  output logic [CW-1:0] cnt_a,
  output logic          vld_a,
  output logic [AW-1:0] src_b,
  output logic [CW-1:0] cnt_b,
  output logic          vld_b,
  output logic          done_clr,
  input  logic          clr_vld_a,
  input  logic          clr_vld_b,
  input  logic          ovr_set,
  input  logic          udr_set,
  input  logic          raw_done,
  input  logic          running,
  input  logic          sel
);
  logic ovr_q, udr_q;

  assign done_clr = reg_we && reg_addr == OFS_STAT && reg_wdata[ST_DONE];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= 1'b0; pp <= 1'b0; ie <= 1'b0;
      period <= '0; burst_m1 <= '0;
      src_a <= '0; cnt_a <= '0; vld_a <= 1'b0;
      src_b <= '0; cnt_b <= '0; vld_b <= 1'b0;
      ovr_q <= 1'b0; udr_q <= 1'b0;
    end else begin
      if (clr_vld_a) vld_a <= 1'b0;
      if (clr_vld_b) vld_b <= 1'b0;
      if (reg_we) begin
        case (reg_addr)
          OFS_CTRL:   begin en <= reg_wdata[0]; pp <= reg_wdata[1]; ie <= reg_wdata[2]; end
          OFS_PERIOD: period   <= reg_wdata[TW-1:0];
          OFS_BURST:  burst_m1 <= reg_wdata[CW-1:0];
          OFS_SRC_A:  src_a    <= reg_wdata[AW-1:0];
          OFS_CNT_A:  begin cnt_a <= reg_wdata[CW-1:0]; vld_a <= 1'b1; end
          OFS_SRC_B:  src_b    <= reg_wdata[AW-1:0];
          OFS_CNT_B:  begin cnt_b <= reg_wdata[CW-1:0]; vld_b <= 1'b1; end
          default: begin
            if (reg_wdata[ST_OVR]) ovr_q <= 1'b0;
            if (reg_wdata[ST_UDR]) udr_q <= 1'b0;
          end
        endcase
      end
      if (ovr_set) ovr_q <= 1'b1;
      if (udr_set) udr_q <= 1'b1;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_CTRL:   reg_rdata[2:0] = {ie, pp, en};
      OFS_PERIOD: reg_rdata[TW-1:0] = period;
      OFS_BURST:  reg_rdata[CW-1:0] = burst_m1;
      OFS_SRC_A:  reg_rdata[AW-1:0] = src_a;
      OFS_CNT_A:  reg_rdata[CW-1:0] = cnt_a;
      OFS_SRC_B:  reg_rdata[AW-1:0] = src_b;
      OFS_CNT_B:  reg_rdata[CW-1:0] = cnt_b;
      default: begin
        reg_rdata[ST_DONE]  = raw_done;
        reg_rdata[ST_OVR]   = ovr_q;
        reg_rdata[ST_UDR]   = udr_q;
        reg_rdata[ST_BUSY]  = running;
        reg_rdata[ST_SEL]   = sel;
        reg_rdata[ST_VLD_A] = vld_a;
        reg_rdata[ST_VLD_B] = vld_b;
      end
    endcase
  end

  // R7: an overrun event is always visible as a sticky flag afterwards
  p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_set |=> ovr_q);
  // R9: an underrun event is always visible as a sticky flag afterwards
  p_udr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    udr_set |=> udr_q);
endmodule

// File: rtl/burst_mover.sv
module burst_mover #(
  parameter int AW = 16,
  parameter int CW = 10,
  localparam int NW = CW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          pp,
  input  logic          req,
  input  logic [CW-1:0] burst_m1,
  input  logic [AW-1:0] src_a,
  input  logic [CW-1:0] cnt_a,
  input  logic          vld_a,
  input  logic [AW-1:0] src_b,
  input  logic [CW-1:0] cnt_b,
  input  logic          vld_b,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [AW-1:0] mem_addr,
  output logic          done_pulse,
  output logic          clr_vld_a,
  output logic          clr_vld_b,
  output logic          ovr_pulse,
  output logic          udr_pulse,
  output logic          running,
  output logic          sel
);
  logic          en_q, pend_q;
  logic [AW-1:0] addr_q;
  logic [NW-1:0] rem_q, beats_q, bsize, first_n;
  logic          bursting, beat, buf_end, oth_vld;
  logic [AW-1:0] oth_src;
  logic [CW-1:0] oth_cnt;

  always_comb begin
    bsize      = NW'(burst_m1) + NW'(1);
    first_n    = (bsize < rem_q) ? bsize : rem_q;
    bursting   = beats_q != '0;
    out_valid  = bursting && en;
    beat       = out_valid && out_ready;
    buf_end    = beat && (rem_q == NW'(1));
    oth_vld    = sel ? vld_a : vld_b;
    oth_src    = sel ? src_a : src_b;
    oth_cnt    = sel ? cnt_a : cnt_b;
    done_pulse = running && buf_end;
    clr_vld_a  = done_pulse && !sel;
    clr_vld_b  = done_pulse && sel;
    ovr_pulse  = en && running && bursting && req && pend_q;
    udr_pulse  = (en && !en_q && !vld_a) || (done_pulse && pp && !oth_vld);
  end

  assign mem_addr = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; pend_q <= 1'b0; running <= 1'b0; sel <= 1'b0;
      addr_q <= '0; rem_q <= '0; beats_q <= '0;
    end else begin
      en_q <= en;
      if (!en) begin
        running <= 1'b0; beats_q <= '0; pend_q <= 1'b0;
      end else if (!en_q) begin
        if (vld_a) begin
          running <= 1'b1; sel <= 1'b0; addr_q <= src_a;
          rem_q   <= NW'(cnt_a) + NW'(1);
        end
        beats_q <= '0; pend_q <= 1'b0;
      end else if (running) begin
        if (bursting) begin
          if (req) pend_q <= 1'b1;
          if (beat) begin
            addr_q  <= addr_q + AW'(2);
            rem_q   <= rem_q - NW'(1);
            beats_q <= beats_q - NW'(1);
          end
        end else if (req || pend_q) begin
          beats_q <= first_n;
          pend_q  <= req && pend_q;
        end
        if (buf_end) begin
          if (pp && oth_vld) begin
            sel    <= !sel;
            addr_q <= oth_src;
            rem_q  <= NW'(oth_cnt) + NW'(1);
          end else begin
            running <= 1'b0;
            pend_q  <= 1'b0;
          end
        end
      end
    end
  end

  // R5: a stalled item stays offered at the same address
  p_hold_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && en) |=> ((out_valid && $stable(mem_addr)) || !en));
  // R4: the address advances by one half-word per accepted item inside a buffer
  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !buf_end) |=> (mem_addr == $past(mem_addr) + AW'(2)));
  // R3: a burst never claims more items than the buffer still holds
  p_burst_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (beats_q <= rem_q && rem_q != '0 && rem_q <= NW'(1 << CW)));
endmodule

// File: rtl/paced_burst_dma.sv
module paced_burst_dma #(
  parameter int AW = 16,
  parameter int TW = 16,
  parameter int CW = 10,
  localparam int DW = (AW > TW) ? AW : TW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic [AW-1:0] mem_addr,
  input  logic [15:0]   mem_rdata,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [15:0]   out_data,
  output logic          irq
);
  logic          en, pp, ie, vld_a, vld_b, done_clr, raw_done, tick;
  logic          done_pulse, clr_vld_a, clr_vld_b, ovr_pulse, udr_pulse, running, sel;
  logic [TW-1:0] period;
  logic [CW-1:0] burst_m1, cnt_a, cnt_b;
  logic [AW-1:0] src_a, src_b;

  pace_regs #(.AW(AW), .TW(TW), .CW(CW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .en(en), .pp(pp), .ie(ie), .period(period), .burst_m1(burst_m1),
    .src_a(src_a), .cnt_a(cnt_a), .vld_a(vld_a),
    .src_b(src_b), .cnt_b(cnt_b), .vld_b(vld_b), .done_clr(done_clr),
    .clr_vld_a(clr_vld_a), .clr_vld_b(clr_vld_b), .ovr_set(ovr_pulse),
    .udr_set(udr_pulse), .raw_done(raw_done), .running(running), .sel(sel)
  );

  pace_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(en), .period(period),
    .done_in(done_pulse), .done_clr(done_clr), .tick(tick), .raw_done(raw_done)
  );

  burst_mover #(.AW(AW), .CW(CW)) u_mover (
    .clk(clk), .rst_n(rst_n), .en(en), .pp(pp), .req(tick), .burst_m1(burst_m1),
    .src_a(src_a), .cnt_a(cnt_a), .vld_a(vld_a),
    .src_b(src_b), .cnt_b(cnt_b), .vld_b(vld_b),
    .out_ready(out_ready), .out_valid(out_valid), .mem_addr(mem_addr),
    .done_pulse(done_pulse), .clr_vld_a(clr_vld_a), .clr_vld_b(clr_vld_b),
    .ovr_pulse(ovr_pulse), .udr_pulse(udr_pulse), .running(running), .sel(sel)
  );

  assign out_data = mem_rdata;
  assign irq      = raw_done && ie;

  // R6: the interrupt only rises on the cycle after a buffer completes
  p_irq_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(done_pulse) || $rose(ie)));
endmodule

// File: tb/paced_burst_dma_bench.sv
`timescale 1ns/1ps
module paced_burst_dma_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata, mem_addr, mem_rdata, out_data;
  logic        out_valid, irq;
  logic        out_ready = 1'b1;
  logic [15:0] mem [256];

  int n_checks = 0, n_fails = 0;
  int stall_mode = 0, tcnt = 0, cyc = 0;
  int t_now = 0, cap_n = 0, rises = 0, cur_len = 0, last_int = 0, prev_rise = 0;
  int irq_busy = 0;
  logic prev_valid = 1'b0;
  logic [15:0] cap [512];

  always #2.5 clk = ~clk;

  assign mem_rdata = mem[mem_addr[8:1]];

  paced_burst_dma u_paced_burst_dma (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .irq(irq)
  );

  // stream monitor
  always @(negedge clk) begin
    t_now = t_now + 1;
    if (out_valid && !prev_valid) begin
      rises = rises + 1; last_int = t_now - prev_rise; prev_rise = t_now; cur_len = 0;
    end
    if (out_valid && out_ready) begin
      cap[cap_n % 512] = out_data; cap_n = cap_n + 1; cur_len = cur_len + 1;
    end
    if (irq && out_valid) irq_busy = irq_busy + 1;
    prev_valid = out_valid;
  end

  function automatic logic [15:0] mem_val(int i);
    return 16'h5A00 ^ 16'(i * 16'h0137);
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  // P, burst items, total items, stall, expected bursts, expected last burst
  localparam int VEC [5][6] = '{
    '{10,  3, 12, 0, 4,  3},
    '{12,  8, 20, 0, 3,  4},
    '{15,  5,  7, 1, 2,  2},
    '{ 6,  1,  4, 0, 4,  1},
    '{20, 16, 16, 1, 1, 16}
  };

  initial begin
    logic [15:0] st;
    for (int i = 0; i < 256; i++) mem[i] = mem_val(i);
    fork
      forever begin
        @(negedge clk); tcnt++;
        case (stall_mode)
          0: out_ready <= 1'b1;
          1: out_ready <= (tcnt % 3) != 0;
          default: out_ready <= 1'b0;
        endcase
      end
      forever begin
        @(posedge clk); cyc++;
        if (cyc > 150000) begin
          chk(1'b0, "watchdog", cyc, 150000);
          summary();
        end
      end
    join_none

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    rd(3'd7, st);
    chk(st == 16'd0, "R10 reset status", st, 0);
    chk(!out_valid, "R5 reset valid", out_valid, 0);
    chk(!irq, "R6 reset irq", irq, 0);
    chk(mem_addr == 16'd0, "R4 reset addr", mem_addr, 0);

    for (int v = 0; v < 5; v++) begin
      int p, b, n, base_n, base_r, base_irq, bad, waited;
      p = VEC[v][0]; b = VEC[v][1]; n = VEC[v][2];
      stall_mode = VEC[v][3];
      wr(3'd0, 16'd0);
      wr(3'd1, 16'(p));
      wr(3'd2, 16'(b - 1));
      wr(3'd3, 16'(v * 64));
      wr(3'd4, 16'(n - 1));
      wr(3'd7, 16'h0007);
      base_n = cap_n; base_r = rises; base_irq = irq_busy;
      wr(3'd0, 16'h0005);
      waited = 0;
      while (((cap_n - base_n) < n || out_valid) && waited < 5000) begin
        @(negedge clk); waited++;
      end
      repeat (3) @(negedge clk);
      chk(cap_n - base_n == n, "R10 total items", cap_n - base_n, n);
      chk(rises - base_r == VEC[v][4], "R2 burst count", rises - base_r, VEC[v][4]);
      chk(cur_len == VEC[v][5], "R3 last burst length", cur_len, VEC[v][5]);
      bad = 0;
      for (int k = 0; k < n; k++)
        if (cap[(base_n + k) % 512] != mem_val(v * 32 + k)) bad++;
      chk(bad == 0, "R4 item order", bad, 0);
      if (VEC[v][3] == 0 && VEC[v][4] >= 2)
        chk(last_int == p + 1, "R1 request spacing", last_int, p + 1);
      rd(3'd7, st);
      chk(st[0] == 1'b1, "R6 done flag", st[0], 1);
      chk(st[3] == 1'b0, "R10 busy cleared", st[3], 0);
      chk(irq == 1'b1, "R6 irq raised", irq, 1);
      chk(irq_busy == base_irq, "R6 no irq mid-buffer", irq_busy - base_irq, 0);
      wr(3'd7, 16'h0001);
      @(negedge clk);
      chk(irq == 1'b0, "R6 w1c clears irq", irq, 0);
    end

    // back-pressure and overrun: ticks every cycle, FIFO full
    begin
      int base_n;
      wr(3'd0, 16'd0);
      stall_mode = 2;
      wr(3'd1, 16'd0);
      wr(3'd2, 16'd3);
      wr(3'd3, 16'h0010);
      wr(3'd4, 16'd39);
      wr(3'd7, 16'h0007);
      base_n = cap_n;
      wr(3'd0, 16'h0001);
      repeat (6) @(negedge clk);
      chk(out_valid == 1'b1, "R5 valid held under stall", out_valid, 1);
      chk(mem_addr == 16'h0010, "R5 address held under stall", mem_addr, 16'h10);
      chk(cap_n == base_n, "R5 no item while not ready", cap_n - base_n, 0);
      rd(3'd7, st);
      chk(st[1] == 1'b1, "R7 overrun flag", st[1], 1);
      wr(3'd0, 16'd0);
      stall_mode = 0;
      wr(3'd7, 16'h0007);
      rd(3'd7, st);
      chk(st[1] == 1'b0, "R7 overrun w1c", st[1], 0);
    end

    // ping-pong: A then B, then underrun on empty A
    begin
      int base_n, base_r, bad, waited;
      wr(3'd1, 16'd8);
      wr(3'd2, 16'd2);
      wr(3'd3, 16'h0100);
      wr(3'd4, 16'd5);
      wr(3'd5, 16'h0180);
      wr(3'd6, 16'd4);
      rd(3'd7, st);
      chk(st[6:5] == 2'b11, "R8 both descriptors valid", st[6:5], 3);
      base_n = cap_n; base_r = rises;
      wr(3'd0, 16'h0003);
      waited = 0;
      while (((cap_n - base_n) < 11 || out_valid) && waited < 5000) begin
        @(negedge clk); waited++;
      end
      repeat (30) @(negedge clk);
      chk(cap_n - base_n == 11, "R8 items across both buffers", cap_n - base_n, 11);
      chk(rises - base_r == 4, "R8 bursts across both buffers", rises - base_r, 4);
      bad = 0;
      for (int k = 0; k < 6; k++) if (cap[(base_n + k) % 512] != mem_val(128 + k)) bad++;
      for (int k = 0; k < 5; k++) if (cap[(base_n + 6 + k) % 512] != mem_val(192 + k)) bad++;
      chk(bad == 0, "R8 switch to alternate source", bad, 0);
      rd(3'd7, st);
      chk(st[6:5] == 2'b00, "R8 finished descriptors released", st[6:5], 0);
      chk(st[2] == 1'b1, "R9 underrun flag", st[2], 1);
      chk(st[3] == 1'b0, "R9 engine stopped", st[3], 0);
      chk(st[0] == 1'b1, "R6 done in ping-pong", st[0], 1);
      chk(irq == 1'b0, "R6 irq gated by enable bit", irq, 0);
      wr(3'd0, 16'd0);
    end

    summary();
  end
endmodule